// File: doc/BRIEF.md
# Stream-to-Memory Write DMA

This block moves one burst of 32-bit words from a ready/valid stream into a word-wide memory-mapped slave. Software programs a byte start address and a byte length through a four-word register window, then sets the go bit. The engine takes words from the stream one at a time. It issues one write per word, with the byte address stepping by four. When the last write has been accepted it sets a done flag, which can raise an interrupt.

A typical use is capturing a fixed-size shot of converter samples into a buffer, which a slower processor then reads at its own pace. Both address and length are byte quantities. A length that is not a whole number of words is refused, and so is a start address that is not word-aligned. A refused request sets an error flag and moves no data.

Register window (word offsets): 0 = start byte address, 1 = byte length, 2 = control, 3 = status. Control bit 0 is go (write-only, reads 0) and bit 1 is interrupt enable. Status bit 0 is busy, bit 1 is done and bit 2 is error. Writing 1 to status bit 1 clears done, and writing 1 to status bit 2 clears error.

Top module: `s2m_write_dma`

## Requirements
- R1: After reset, status reads 0, irq is low, st_ready is low and m_write is low.
- R2: The k-th word of a transfer (k from 0) is written at byte address start+4k, with m_be equal to 4'hF and the address's two low bits zero.
- R3: A transfer of length L bytes takes exactly L/4 words from the stream and issues exactly L/4 accepted writes. Busy then clears, and st_ready stays low afterwards.
- R4: A go request is refused when the length is 0, is not a multiple of 4, or exceeds MAX_BYTES (default 65536), or when start address bits [1:0] are non-zero. A refused request leaves busy low, writes nothing, takes no stream word and sets status bit 2.
- R5: An accepted go clears status bit 2. Writing 1 to status bit 2 also clears it.
- R6: A go written while busy is ignored. The running transfer keeps its original length and no error is raised.
- R7: While m_write is high and m_wait is high, m_addr, m_wdata and m_write hold and st_ready is low. Words reach memory in stream order, with none lost or repeated.
- R8: Status bit 1 (done) sets in the cycle busy clears at the end of a transfer. Writing 1 to status bit 1 clears it.
- R9: irq is high exactly while done is set and control bit 1 (interrupt enable) is set.
- R10: Offsets 0 and 1 read back the last written address and length. Offset 2 reads interrupt enable in bit 1 and 0 in bit 0.
- R11: A length of exactly MAX_BYTES is accepted and moves MAX_BYTES/4 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 2 | Register word offset |
| cfg_write | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Completion interrupt |
| st_data | input | 32 | Stream word |
| st_valid | input | 1 | Stream word present |
| st_ready | output | 1 | Stream word taken when high with st_valid |
| m_addr | output | 32 | Write byte address |
| m_wdata | output | 32 | Write data |
| m_be | output | 4 | Byte enables |
| m_write | output | 1 | Write request |
| m_wait | input | 1 | Slave stall; a write is accepted in a cycle with m_write high and m_wait low |

## Verification
The assertions assume that m_wait is meaningful only while m_write is high. They also assume that the stream side is sampled only on a cycle where st_valid and st_ready are both high, so valid may drop or rise freely. The bench drives valid and wait from several fixed cycle patterns, including constant, alternating and uneven ones. It offers a few more stream words than each transfer needs, so that over-consumption would show. Register writes come only through the single-cycle strobe. Go is issued while busy only in the dedicated R6 case.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;

  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_LEN  = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Length accepted: non-zero, whole words, within the descriptor limit.
  function automatic logic len_ok(input logic [31:0] len, input logic [31:0] max_b);
    return (len != 32'd0) && (len[1:0] == 2'b00) && (len <= max_b);
  endfunction

  // Start address accepted: word-aligned.
  function automatic logic addr_ok(input logic [31:0] a);
    return a[1:0] == 2'b00;
  endfunction

  // Number of 32-bit words in a byte length.
  function automatic logic [31:0] words_of(input logic [31:0] len);
    return len >> 2;
  endfunction

  // Next byte address after one word.
  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [31:0] bytes);
    return a + bytes;
  endfunction

endpackage

// File: rtl/dma_wr_regs.sv
module dma_wr_regs
  import dma_wr_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int MAX_BYTES = 65536,
  parameter int WCNT_W    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_addr,
  input  logic              cfg_write,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              busy,
  input  logic              xfer_done,
  output logic              start_evt,
  output logic              reject_evt,
  output logic [CFG_W-1:0]  start_addr,
  output logic [WCNT_W-1:0] start_words,
  output logic              done_q,
  output logic              err_q,
  output logic              irq_en_q,
  output logic              irq
);

  logic [CFG_W-1:0] addr_q;
  logic [CFG_W-1:0] len_q;
  logic             go_wr;
  logic             req_ok;
  logic             stat_wr;

  assign go_wr   = cfg_write && (cfg_addr == REG_CTRL) && cfg_wdata[0];
  assign stat_wr = cfg_write && (cfg_addr == REG_STAT);
  assign req_ok  = len_ok(len_q, 32'(MAX_BYTES)) && addr_ok(addr_q);

  assign start_evt   = go_wr && !busy && req_ok;
  assign reject_evt  = go_wr && !busy && !req_ok;
  assign start_addr  = addr_q;
  assign start_words = WCNT_W'(words_of(len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      len_q    <= '0;
      irq_en_q <= 1'b0;
    end else if (cfg_write) begin
      case (cfg_addr)
        REG_ADDR: addr_q   <= cfg_wdata;
        REG_LEN:  len_q    <= cfg_wdata;
        REG_CTRL: irq_en_q <= cfg_wdata[1];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (xfer_done) begin
      done_q <= 1'b1;
    end else if (stat_wr && cfg_wdata[1]) begin
      done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (reject_evt) begin
      err_q <= 1'b1;
    end else if (start_evt || (stat_wr && cfg_wdata[2])) begin
      err_q <= 1'b0;
    end
  end

  assign irq = done_q && irq_en_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_ADDR: cfg_rdata = addr_q;
      REG_LEN:  cfg_rdata = len_q;
      REG_CTRL: cfg_rdata[1] = irq_en_q;
      default:  cfg_rdata[2:0] = {err_q, done_q, busy};
    endcase
  end

endmodule

// File: rtl/dma_wr_engine.sv
module dma_wr_engine
  import dma_wr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WCNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WCNT_W-1:0] start_words,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_valid,
  output logic              st_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_be,
  output logic              m_write,
  input  logic              m_wait,
  output logic              busy,
  output logic              xfer_done
);

  localparam int BE_W = DATA_W / 8;

  logic [ADDR_W-1:0] nxt_addr;
  logic [WCNT_W-1:0] left;
  logic              pend;
  logic              accepted;
  logic              take;

  assign accepted  = pend && !m_wait;
  assign st_ready  = busy && (left != '0) && (!pend || !m_wait);
  assign take      = st_valid && st_ready;
  assign xfer_done = busy && accepted && (left == '0);
  assign m_write   = pend;
  assign m_be      = {BE_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      nxt_addr <= '0;
      left     <= '0;
      m_addr   <= '0;
      m_wdata  <= '0;
    end else if (start_evt) begin
      busy     <= 1'b1;
      pend     <= 1'b0;
      nxt_addr <= start_addr;
      left     <= start_words;
    end else if (busy) begin
      if (take) begin
        pend     <= 1'b1;
        m_addr   <= nxt_addr;
        m_wdata  <= st_data;
        nxt_addr <= ADDR_W'(step_addr(32'(nxt_addr), 32'(BE_W)));
        left     <= left - 1'b1;
      end else if (accepted) begin
        pend <= 1'b0;
      end
      if (xfer_done) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/s2m_write_dma.sv
module s2m_write_dma #(
  parameter int CFG_W     = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_addr,
  input  logic              cfg_write,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              irq,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_valid,
  output logic              st_ready,
  output logic [CFG_W-1:0]  m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_be,
  output logic              m_write,
  input  logic              m_wait
);

  localparam int WORD_B = DATA_W / 8;
  localparam int WCNT_W = $clog2(MAX_BYTES / WORD_B) + 1;

  logic              start_evt;
  logic              reject_evt;
  logic              xfer_done;
  logic              busy;
  logic              done_q;
  logic              err_q;
  logic              irq_en_q;
  logic [CFG_W-1:0]  start_addr;
  logic [WCNT_W-1:0] start_words;

  dma_wr_regs #(
    .CFG_W(CFG_W), .MAX_BYTES(MAX_BYTES), .WCNT_W(WCNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .xfer_done(xfer_done),
    .start_evt(start_evt), .reject_evt(reject_evt),
    .start_addr(start_addr), .start_words(start_words),
    .done_q(done_q), .err_q(err_q), .irq_en_q(irq_en_q), .irq(irq)
  );

  dma_wr_engine #(
    .ADDR_W(CFG_W), .DATA_W(DATA_W), .WCNT_W(WCNT_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start_evt(start_evt), .start_addr(start_addr), .start_words(start_words),
    .st_data(st_data), .st_valid(st_valid), .st_ready(st_ready),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be), .m_write(m_write), .m_wait(m_wait),
    .busy(busy), .xfer_done(xfer_done)
  );

endmodule

// File: rtl/dma_wr_checker.sv
module dma_wr_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WCNT_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              reject_evt,
  input logic              xfer_done,
  input logic              busy,
  input logic              done_q,
  input logic              err_q,
  input logic [WCNT_W-1:0] start_words,
  input logic              st_ready,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic [DATA_W/8-1:0] m_be,
  input logic              m_write,
  input logic              m_wait
);

  logic [31:0] acc_cnt;
  logic [31:0] exp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      exp_cnt <= '0;
    end else if (start_evt) begin
      acc_cnt <= '0;
      exp_cnt <= 32'(start_words);
    end else if (m_write && !m_wait) begin
      acc_cnt <= acc_cnt + 1;
    end
  end

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> (m_addr[1:0] == 2'b00) && (&m_be));

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (acc_cnt + 1 == exp_cnt));

  p_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> busy);

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> err_q && !busy);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_wait) |=> m_write && $stable(m_addr) && $stable(m_wdata));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_wait) |-> !st_ready);

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_q && !busy);

endmodule

bind s2m_write_dma dma_wr_checker #(
  .ADDR_W(CFG_W), .DATA_W(DATA_W), .WCNT_W(WCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_evt(start_evt), .reject_evt(reject_evt), .xfer_done(xfer_done),
  .busy(busy), .done_q(done_q), .err_q(err_q), .start_words(start_words),
  .st_ready(st_ready), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
  .m_write(m_write), .m_wait(m_wait)
);

// File: tb/test_s2m_write_dma.sv
`timescale 1ns/1ps
module test_s2m_write_dma;

  localparam int MAXB = 65536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_addr = 2'd3;
  logic        cfg_write = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;
  logic [31:0] st_data = '0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] m_addr;
  logic [31:0] m_wdata;
  logic [3:0]  m_be;
  logic        m_write;
  logic        m_wait = 1'b0;

  s2m_write_dma i_s2m_write_dma (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq(irq),
    .st_data(st_data), .st_valid(st_valid), .st_ready(st_ready),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be), .m_write(m_write), .m_wait(m_wait)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int unsigned cyc = 0;
  int src_idx = 0;
  int src_avail = 0;
  int wr_n = 0;
  int bad_addr = 0;
  int bad_data = 0;
  int bad_be = 0;
  int vmode = 0;
  int wmode = 0;
  logic [31:0] cur_base = '0;
  logic [31:0] data_seed = '0;

  function automatic bit vpat(int m, int unsigned c);
    case (m)
      0: return 1'b1;
      1: return c[0];
      default: return ((c * 7) % 5) != 0;
    endcase
  endfunction

  function automatic bit wpat(int m, int unsigned c);
    case (m)
      0: return 1'b0;
      1: return c[0];
      2: return (c % 3) == 0;
      default: return ((c * 5) % 7) < 3;
    endcase
  endfunction

  // Monitor at the edge, then drive shortly after it.
  always @(posedge clk) begin
    if (st_valid && st_ready) src_idx++;
    if (m_write && !m_wait) begin
      if (m_addr !== cur_base + 32'(4 * wr_n)) bad_addr++;
      if (m_wdata !== data_seed + 32'(wr_n)) bad_data++;
      if (m_be !== 4'hF) bad_be++;
      wr_n++;
    end
    cyc++;
    #1;
    st_valid = (src_idx < src_avail) && vpat(vmode, cyc);
    st_data  = data_seed + 32'(src_idx);
    m_wait   = wpat(wmode, cyc);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_addr = a; cfg_wdata = d; cfg_write = 1'b1;
    @(posedge clk); #2;
    cfg_write = 1'b0; cfg_addr = 2'd3;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
    cfg_addr = 2'd3;
  endtask

  task automatic arm(input logic [31:0] a, input int words, input int vm, input int wm);
    cur_base = a; data_seed = a ^ 32'h3C00_0000;
    src_idx = 0; src_avail = words + 3; wr_n = 0;
    bad_addr = 0; bad_data = 0; bad_be = 0;
    vmode = vm; wmode = wm;
  endtask

  task automatic wait_idle(input int limit);
    int t = 0;
    @(negedge clk);
    while (cfg_rdata[0] && t < limit) begin
      @(negedge clk);
      t++;
    end
    chk(t < limit, "R3", "transfer finished in time", 32'(t), 32'(limit));
  endtask

  task automatic run_xfer(input logic [31:0] a, input logic [31:0] len,
                          input int vm, input int wm, input bit ie);
    int n;
    logic [31:0] st;
    n = int'(len / 4);
    arm(a, n, vm, wm);
    reg_wr(2'd0, a);
    reg_wr(2'd1, len);
    reg_wr(2'd2, {30'd0, ie, 1'b1});
    wait_idle(n * 12 + 100);
    repeat (6) @(negedge clk);
    chk(wr_n == n, "R3", "accepted writes", 32'(wr_n), 32'(n));
    chk(src_idx == n, "R3", "stream words taken", 32'(src_idx), 32'(n));
    chk(bad_addr == 0 && bad_be == 0, "R2", "byte address / enables", 32'(bad_addr + bad_be), 32'd0);
    chk(bad_data == 0, "R7", "data order", 32'(bad_data), 32'd0);
    chk(st_ready == 1'b0, "R3", "st_ready after end", {31'd0, st_ready}, 32'd0);
    reg_rd(2'd3, st);
    chk(st[2:0] == 3'b010, "R8", "status after end (R5 error clear)", st, 32'h2);
    chk(irq == ie, "R9", "irq at end", {31'd0, irq}, {31'd0, ie});
    reg_wr(2'd3, 32'h2);
    reg_rd(2'd3, st);
    chk(st[1] == 1'b0, "R8", "done cleared", st, 32'h0);
    chk(irq == 1'b0, "R9", "irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic reject_case(input logic [31:0] a, input logic [31:0] len);
    logic [31:0] st;
    arm(a, 4, 0, 0);
    reg_wr(2'd0, a);
    reg_wr(2'd1, len);
    reg_wr(2'd2, 32'h1);
    repeat (8) @(negedge clk);
    reg_rd(2'd3, st);
    chk(st[2:0] == 3'b100, "R4", "status after refused go", st, 32'h4);
    chk(wr_n == 0 && src_idx == 0, "R4", "no data moved", 32'(wr_n + src_idx), 32'd0);
    reg_wr(2'd3, 32'h4);
    reg_rd(2'd3, st);
    chk(st[2] == 1'b0, "R5", "error write-one-clear", st, 32'h0);
    reg_wr(2'd2, 32'h1);
    repeat (2) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    @(posedge clk);
    while (!finished && cyc < 190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cfg_rdata == 32'h0, "R1", "status after reset", cfg_rdata, 32'h0);
    chk(!irq && !st_ready && !m_write, "R1", "outputs after reset",
        {29'd0, irq, st_ready, m_write}, 32'h0);

    // R10: register readback
    reg_wr(2'd0, 32'h1234_5678);
    reg_rd(2'd0, rd);
    chk(rd == 32'h1234_5678, "R10", "address readback", rd, 32'h1234_5678);
    reg_wr(2'd1, 32'h0000_ABCD);
    reg_rd(2'd1, rd);
    chk(rd == 32'h0000_ABCD, "R10", "length readback", rd, 32'h0000_ABCD);
    reg_wr(2'd2, 32'h2);
    reg_rd(2'd2, rd);
    chk(rd == 32'h2, "R10", "control readback", rd, 32'h2);
    reg_wr(2'd2, 32'h0);

    // R4: refused lengths and addresses
    for (int l = 0; l < 12; l++)
      if (l % 4 != 0 || l == 0) reject_case(32'h100, 32'(l));
    reject_case(32'h100, 32'(MAXB + 4));
    reject_case(32'h100, 32'(MAXB + 1));
    for (int b = 1; b < 4; b++) reject_case(32'h200 + 32'(b), 32'd16);

    // R5: an accepted go clears a pending error
    reject_case(32'h300, 32'd6);
    reg_wr(2'd0, 32'h300); reg_wr(2'd1, 32'd5); reg_wr(2'd2, 32'h1);
    run_xfer(32'h400, 32'd8, 0, 0, 1'b0);

    // R2/R3/R7/R8/R9 sweep over lengths, stall and valid patterns
    for (int w = 0; w < 4; w++)
      for (int l = 4; l <= 64; l += 4)
        run_xfer(32'h1000 * 32'(w + 1) + 32'(l * 16), 32'(l), l % 3, w, (l / 4) % 2 == 1);

    // R6: go while busy is ignored
    arm(32'h9000, 10, 1, 3);
    reg_wr(2'd0, 32'h9000);
    reg_wr(2'd1, 32'd40);
    reg_wr(2'd2, 32'h3);
    reg_wr(2'd1, 32'd8);
    reg_wr(2'd2, 32'h3);
    wait_idle(400);
    repeat (6) @(negedge clk);
    chk(wr_n == 10, "R6", "writes with go while busy", 32'(wr_n), 32'd10);
    chk(bad_addr == 0 && bad_data == 0, "R6", "content with go while busy", 32'(bad_addr + bad_data), 32'd0);
    reg_rd(2'd3, rd);
    chk(rd[2:0] == 3'b010, "R6", "no error from ignored go", rd, 32'h2);
    reg_wr(2'd3, 32'h2);

    // R11: maximum length accepted
    run_xfer(32'h8000_0000, 32'(MAXB), 0, 0, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule